// File: doc/BRIEF.md
# Half-Rate Dual-Edge Deserializer

This block turns a serial bit stream into parallel words while running on a clock at half the bit rate. Each clock period carries two bits. The first bit of the period is captured on the rising edge and the second on the falling edge. Two short shift chains hold the bits. One chain collects the odd-numbered bits of a word and the other collects the even-numbered bits. With the default 8-bit word, each chain is four stages long and a complete word forms every four clock cycles. For example, a 1.25 Gb/s stream is received with a 625 MHz clock and produces words at 156.25 MHz.

A free-running phase counter counts rising edges from reset. Once all eight bits of a word sit in the chains, the interleaved word is loaded into an output register and a one-cycle valid strobe is raised. Word alignment is fixed by reset: the first rising edge after reset is taken as bit D1. Clock recovery and the search for word boundaries belong to the surrounding logic.

Top module: `dual_edge_deser`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `word_out` reads 0 and `word_vld` reads 0.
- R2: Within each clock period, the bit sampled on the rising edge is an odd-numbered bit and the bit sampled on the falling edge is the next even-numbered bit. The first bit received, D1, appears on `word_out[7]`, and the eighth bit, D8, appears on `word_out[0]`.
- R3: The serial sequence 1,1,0,1,0,1,1,0 (first bit first) is presented as `word_out` = 8'b11010110.
- R4: On a continuous stream, `word_vld` is high for exactly one clock cycle, and it rises exactly once every four clock cycles.
- R5: After reset is released, `word_vld` first rises at the fifth rising edge. By then eight bits have been received, and `word_out` carries those first eight bits.
- R6: `word_out` changes only on a rising edge that also raises `word_vld`. Between strobes it holds its value.
- R7: The all-zero word and the all-one word are recovered unchanged, as are words that alternate between these and other patterns back to back.
- R8: Asserting reset in the middle of a word discards the partly received bits. The first bit after release becomes D1 of the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock; both edges sample data |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, two bits per clock period |
| word_out | output | 8 | Recovered word, D1 in the MSB |
| word_vld | output | 1 | One-cycle strobe marking a new word |

## Verification
On the rising edge that loads a finished word into `word_out`, the rising-edge chain also captures D1 of the following word. Output capture and new-word sampling therefore fall in the same cycle. The bench provokes this collision by sending the stimulus words back to back with no idle bits between them, using patterns such as 00/FF and 55/AA in which every bit flips between neighbouring words. It judges the outcome by comparing each strobed word with the word the serializer model sent, and by checking that the strobe spacing stays at four cycles across the boundaries.

// File: rtl/dual_edge_deser.sv
module dual_edge_deser #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);

  localparam int HALF = WORD_W / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HALF-1:0]   odd_q;
  logic [HALF-1:0]   even_q;
  logic [CW-1:0]     phase;
  logic              primed;
  logic [WORD_W-1:0] word_nxt;
  logic              wrap;
  logic              load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) odd_q <= '0;
    else        odd_q <= {odd_q[HALF-2:0], ser_in};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) even_q <= '0;
    else        even_q <= {even_q[HALF-2:0], ser_in};

  assign wrap = (phase == CW'(HALF-1));
  assign load = primed && (phase == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= '0;
      primed <= 1'b0;
    end else begin
      phase  <= wrap ? '0 : phase + 1'b1;
      primed <= primed | wrap;
    end

  genvar i;
  generate
    for (i = 0; i < HALF; i++) begin : g_weave
      assign word_nxt[WORD_W-1-2*i] = odd_q[HALF-1-i];
      assign word_nxt[WORD_W-2-2*i] = even_q[HALF-1-i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      if (load) word_out <= word_nxt;
      word_vld <= load;
    end

  logic [CW+1:0] rise_seen;
  logic [CW+1:0] gap;
  logic          had_vld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_seen <= '0;
      gap       <= '0;
      had_vld   <= 1'b0;
    end else begin
      if (rise_seen != (CW+2)'(HALF+1)) rise_seen <= rise_seen + 1'b1;
      if (word_vld)       gap <= '0;
      else if (~&gap)     gap <= gap + 1'b1;
      if (word_vld) had_vld <= 1'b1;
    end

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  // R4
  vld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && had_vld) |-> (gap == (CW+2)'(HALF-1)));

  // R5
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (rise_seen == (CW+2)'(HALF+1)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (word_vld || $stable(word_out)));

endmodule

// File: tb/sim_dual_edge_deser.sv
module sim_dual_edge_deser;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n  = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] word_out;
  logic       word_vld;

  dual_edge_deser #(.WORD_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .word_out(word_out), .word_vld(word_vld)
  );

  localparam int NV = 8;
  localparam logic [7:0] VEC [0:NV-1] = '{8'hD6, 8'h00, 8'hFF, 8'h55,
                                          8'hAA, 8'h81, 8'h7E, 8'h3C};

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [0:63];
  string      tag_q [0:63];
  int wr = 0, rd = 0;
  int ncnt = 0, last_n = 0;
  bit seen = 0;
  logic [7:0] held = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w, input bit track, input string tag);
    if (track) begin
      exp_q[wr] = w;
      tag_q[wr] = tag;
      wr++;
    end
    for (int k = 0; k < 4; k++) begin
      ser_in = w[7-2*k];
      @(posedge clk); #1;
      ser_in = w[6-2*k];
      @(negedge clk); #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      ncnt = 0;
      seen = 0;
      held = '0;
    end else begin
      ncnt++;
      if (word_vld) begin
        if (!seen) chk(ncnt == 5, "R5 first strobe cycle", ncnt, 5);
        else       chk(ncnt - last_n == 4, "R4 strobe spacing", ncnt - last_n, 4);
        seen   = 1;
        last_n = ncnt;
        if (rd < wr) begin
          chk(word_out == exp_q[rd], tag_q[rd], word_out, exp_q[rd]);
          rd++;
        end
        held = word_out;
      end else begin
        chk(word_out == held, "R6 hold between strobes", word_out, held);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    ser_in = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(word_out == 8'h00, "R1 reset word", word_out, 0);
    chk(word_vld == 1'b0, "R1 reset strobe", word_vld, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      send_word(VEC[v], 1'b1,
                (VEC[v] == 8'hD6) ? "R3 sample stream" :
                ((VEC[v] == 8'h00 || VEC[v] == 8'hFF) ? "R7 uniform word" : "R2 bit order"));
    ser_in = 1'b0;
    repeat (12) @(negedge clk);
    #1;
    chk(rd == wr, "R4 every word strobed", rd, wr);

    ser_in = 1'b1;
    repeat (2) begin
      @(posedge clk); #1;
      @(negedge clk); #1;
    end
    rst_n = 1'b0;
    #1;
    chk(word_out == 8'h00, "R1 R8 mid-word reset word", word_out, 0);
    chk(word_vld == 1'b0, "R1 R8 mid-word reset strobe", word_vld, 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    send_word(8'hFF, 1'b1, "R8 realign after reset");
    send_word(8'h00, 1'b1, "R8 realign after reset");
    send_word(8'h81, 1'b1, "R8 realign after reset");
    ser_in = 1'b0;
    repeat (12) @(negedge clk);
    #1;
    chk(rd == wr, "R8 words after reset strobed", rd, wr);
    finish_run();
  end
endmodule